// File: doc/BRIEF.md
# Transmit Buffer Index Manager

This block keeps the write and read positions for the transmit portion of a message-buffer area that begins with a run of dedicated buffers and continues with a shared section. The shared section works either as a first-in first-out ring or as a queue. The block publishes those positions, plus an occupancy figure and a full flag, both as separate outputs and packed into one read-only 32-bit status word. Every index is an absolute buffer number counted from buffer 0. Buffer 0 is the first dedicated buffer, so the shared section starts at the index equal to the dedicated count.

The host pulses `add_stb` each time it places a frame into the shared section. The transmit engine pulses `done_stb` together with a buffer number each time a frame finishes sending or is cancelled. In ring mode the write position advances on each accepted add, and the read position advances when the buffer at the read position completes. In queue mode the write position always names the lowest-numbered queue buffer that holds no pending frame. The read position and the free count both show zero in queue mode.

The configuration inputs are the dedicated count, the section size and the mode. When any of them changes, the next clock edge restarts the section as empty. All outputs are registered, so each one reflects the strobes sampled at the clock edge just before it.

Top module: `txq_index_mgr`

## Requirements
- R1: In ring mode the write and read indexes are absolute buffer numbers that stay within [ded, ded+size). With ded=12 and size=20, three accepted adds after a restart give a write index of 15.
- R2: In ring mode an accepted add moves the write index to the next buffer. From the last section buffer (ded+size-1) it returns to ded and never enters the dedicated range.
- R3: In ring mode, a completion whose buffer number equals the read index, arriving while the ring holds at least one frame, moves the read index forward with the same wrap rule. Any other completion has no effect.
- R4: In ring mode the free level equals size minus the number of held frames, over the range 0 to 32. The full flag is 1 exactly when the free level is 0.
- R5: An add that arrives while the full flag is set is ignored. The write index, read index and free level all stay unchanged.
- R6: In queue mode the read index and free level output 0. The write index shows the lowest section buffer without a pending frame, or ded if every buffer is pending, and the full flag is then 1. An add marks the buffer shown as pending. A completion with a buffer number inside the section clears that buffer's pending mark.
- R7: The status word places the full flag at bit 21, the write index at bits 20:16, the read index at bits 12:8 and the free level at bits 5:0. Every other bit is 0.
- R8: While reset is high, all outputs are 0 (status word 0x00000000). At the first edge after reset is released, and at the first edge after any configuration change, the write and read indexes become ded, the free level becomes size and the section is empty. Strobes sampled at that edge are dropped.
- R9: Outputs change only at a clock edge. A strobe driven between edges does not move any output before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ded | input | 6 | Number of dedicated buffers ahead of the section |
| cfg_size | input | 6 | Number of buffers in the ring or queue section |
| cfg_queue | input | 1 | 0 selects ring mode, 1 selects queue mode |
| add_stb | input | 1 | Host placed one frame into the section |
| done_stb | input | 1 | One buffer finished sending or was cancelled |
| done_idx | input | 5 | Absolute buffer number for `done_stb` |
| put_idx | output | 5 | Write index |
| get_idx | output | 5 | Read index, 0 in queue mode |
| free_lvl | output | 6 | Free buffers in the ring, 0 in queue mode |
| full | output | 1 | No free buffer in the section |
| status | output | 32 | Packed read-only status word |

## Verification
The properties assume the sum ded+size is at most 32 and the size is at least 1. They apply only once the configuration has held steady for three edges, because each change triggers a restart that legitimately resets the indexes. The bench draws every configuration inside those bounds and holds each one for hundreds of cycles. Completion numbers in ring mode are usually the current read index and sometimes arbitrary. In queue mode they always fall inside the section.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic {
    MODE_RING  = 1'b0,
    MODE_QUEUE = 1'b1
  } txq_mode_e;

  // Bit positions inside the packed status word
  localparam int ST_FULL_BIT = 21;
  localparam int ST_PUT_LSB  = 16;
  localparam int ST_GET_LSB  = 8;
  localparam int ST_FREE_LSB = 0;

endpackage

// File: rtl/txq_ring_ptr.sv
module txq_ring_ptr #(
  parameter int IDX_W = 5,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             active,
  input  logic             add,
  input  logic             done,
  input  logic [IDX_W-1:0] done_idx,
  input  logic [LVL_W-1:0] ded,
  input  logic [LVL_W-1:0] size,
  output logic [IDX_W-1:0] put_n,
  output logic [IDX_W-1:0] get_n,
  output logic [LVL_W-1:0] fill_n,
  output logic             full_n
);

  logic [IDX_W-1:0] put_q, get_q;
  logic [LVL_W-1:0] fill_q;
  logic [LVL_W:0]   last;
  logic [IDX_W-1:0] first;
  logic             do_add, do_get;

  function automatic logic [IDX_W-1:0] advance(input logic [IDX_W-1:0] p,
                                               input logic [LVL_W:0]   lst,
                                               input logic [IDX_W-1:0] fst);
    if ((LVL_W+1)'(p) == lst) return fst;
    return IDX_W'(p + 1);
  endfunction

  always_comb begin
    last   = (LVL_W+1)'(ded) + (LVL_W+1)'(size) - (LVL_W+1)'(1);
    first  = ded[IDX_W-1:0];
    do_add = active && add && (fill_q != size);
    do_get = active && done && (fill_q != '0) && (done_idx == get_q);
    if (init) begin
      put_n  = first;
      get_n  = first;
      fill_n = '0;
    end else begin
      put_n  = do_add ? advance(put_q, last, first) : put_q;
      get_n  = do_get ? advance(get_q, last, first) : get_q;
      fill_n = fill_q + LVL_W'(do_add) - LVL_W'(do_get);
    end
    full_n = (fill_n == size);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      put_q  <= '0;
      get_q  <= '0;
      fill_q <= '0;
    end else begin
      put_q  <= put_n;
      get_q  <= get_n;
      fill_q <= fill_n;
    end
  end

endmodule

// File: rtl/txq_queue_map.sv
module txq_queue_map #(
  parameter int NBUF  = 32,
  parameter int IDX_W = 5,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             active,
  input  logic             add,
  input  logic             done,
  input  logic [IDX_W-1:0] done_idx,
  input  logic [LVL_W-1:0] ded,
  input  logic [LVL_W-1:0] size,
  output logic [IDX_W-1:0] put_n,
  output logic             full_n
);

  logic [NBUF-1:0]  pend_q, pend_n;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_ok, nxt_ok;
  logic [LVL_W:0]   lo_x, hi_x, didx_x;

  // Lowest section buffer with no pending frame: {found, index}
  function automatic logic [IDX_W:0] lowest_free(input logic [NBUF-1:0] m,
                                                 input logic [LVL_W:0]  lo,
                                                 input logic [LVL_W:0]  hi);
    logic [IDX_W:0] r;
    r = {1'b0, lo[IDX_W-1:0]};
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (((LVL_W+1)'(i) >= lo) && ((LVL_W+1)'(i) < hi) && !m[i]) begin
        r = {1'b1, IDX_W'(i)};
      end
    end
    return r;
  endfunction

  always_comb begin
    lo_x   = (LVL_W+1)'(ded);
    hi_x   = (LVL_W+1)'(ded) + (LVL_W+1)'(size);
    didx_x = (LVL_W+1)'(done_idx);
    {cur_ok, cur_idx} = lowest_free(pend_q, lo_x, hi_x);
    pend_n = pend_q;
    if (init) begin
      pend_n = '0;
    end else if (active) begin
      if (done && (didx_x >= lo_x) && (didx_x < hi_x)) pend_n[done_idx] = 1'b0;
      if (add && cur_ok) pend_n[cur_idx] = 1'b1;
    end
    {nxt_ok, put_n} = lowest_free(pend_n, lo_x, hi_x);
    full_n = !nxt_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_n;
  end

endmodule

// File: rtl/txq_status_reg.sv
module txq_status_reg
  import txq_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int LVL_W  = 6,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  txq_mode_e         mode,
  input  logic [IDX_W-1:0]  put_n,
  input  logic [IDX_W-1:0]  get_n,
  input  logic [LVL_W-1:0]  free_n,
  input  logic              full_n,
  output logic [IDX_W-1:0]  put_idx,
  output logic [IDX_W-1:0]  get_idx,
  output logic [LVL_W-1:0]  free_lvl,
  output logic              full,
  output logic [STAT_W-1:0] status
);

  logic [IDX_W-1:0]  get_v;
  logic [LVL_W-1:0]  free_v;
  logic [STAT_W-1:0] word_v;

  always_comb begin
    get_v  = (mode == MODE_QUEUE) ? '0 : get_n;
    free_v = (mode == MODE_QUEUE) ? '0 : free_n;
    word_v = '0;
    word_v[ST_FULL_BIT]                   = full_n;
    word_v[ST_PUT_LSB  +: IDX_W]          = put_n;
    word_v[ST_GET_LSB  +: IDX_W]          = get_v;
    word_v[ST_FREE_LSB +: LVL_W]          = free_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      put_idx  <= '0;
      get_idx  <= '0;
      free_lvl <= '0;
      full     <= 1'b0;
      status   <= '0;
    end else begin
      put_idx  <= put_n;
      get_idx  <= get_v;
      free_lvl <= free_v;
      full     <= full_n;
      status   <= word_v;
    end
  end

endmodule

// File: rtl/txq_index_mgr.sv
module txq_index_mgr
  import txq_pkg::*;
#(
  parameter int NBUF   = 32,
  parameter int IDX_W  = $clog2(NBUF),
  parameter int LVL_W  = IDX_W + 1,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  cfg_ded,
  input  logic [LVL_W-1:0]  cfg_size,
  input  logic              cfg_queue,
  input  logic              add_stb,
  input  logic              done_stb,
  input  logic [IDX_W-1:0]  done_idx,
  output logic [IDX_W-1:0]  put_idx,
  output logic [IDX_W-1:0]  get_idx,
  output logic [LVL_W-1:0]  free_lvl,
  output logic              full,
  output logic [STAT_W-1:0] status
);

  localparam int CFG_W = 2 * LVL_W + 1;

  txq_mode_e        mode;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             cfg_vld;
  logic             init;

  logic [IDX_W-1:0] r_put, r_get, q_put;
  logic [LVL_W-1:0] r_fill;
  logic             r_full, q_full;

  logic [IDX_W-1:0] put_n;
  logic [LVL_W-1:0] free_n;
  logic             full_n;

  assign mode    = cfg_queue ? MODE_QUEUE : MODE_RING;
  assign cfg_now = {cfg_queue, cfg_ded, cfg_size};
  assign init    = !cfg_vld || (cfg_now != cfg_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      cfg_vld <= 1'b0;
    end else begin
      cfg_q   <= cfg_now;
      cfg_vld <= 1'b1;
    end
  end

  txq_ring_ptr #(.IDX_W(IDX_W), .LVL_W(LVL_W)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .init     (init),
    .active   (mode == MODE_RING),
    .add      (add_stb),
    .done     (done_stb),
    .done_idx (done_idx),
    .ded      (cfg_ded),
    .size     (cfg_size),
    .put_n    (r_put),
    .get_n    (r_get),
    .fill_n   (r_fill),
    .full_n   (r_full)
  );

  txq_queue_map #(.NBUF(NBUF), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .init     (init),
    .active   (mode == MODE_QUEUE),
    .add      (add_stb),
    .done     (done_stb),
    .done_idx (done_idx),
    .ded      (cfg_ded),
    .size     (cfg_size),
    .put_n    (q_put),
    .full_n   (q_full)
  );

  always_comb begin
    if (mode == MODE_QUEUE) begin
      put_n  = q_put;
      full_n = q_full;
    end else begin
      put_n  = r_put;
      full_n = r_full;
    end
    free_n = cfg_size - r_fill;
  end

  txq_status_reg #(.IDX_W(IDX_W), .LVL_W(LVL_W), .STAT_W(STAT_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .put_n    (put_n),
    .get_n    (r_get),
    .free_n   (free_n),
    .full_n   (full_n),
    .put_idx  (put_idx),
    .get_idx  (get_idx),
    .free_lvl (free_lvl),
    .full     (full),
    .status   (status)
  );

endmodule

// File: rtl/txq_index_mgr_chk.sv
module txq_index_mgr_chk #(
  parameter int IDX_W  = 5,
  parameter int LVL_W  = 6,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [LVL_W-1:0]  cfg_ded,
  input logic [LVL_W-1:0]  cfg_size,
  input logic              cfg_queue,
  input logic              add_stb,
  input logic              done_stb,
  input logic [IDX_W-1:0]  put_idx,
  input logic [IDX_W-1:0]  get_idx,
  input logic [LVL_W-1:0]  free_lvl,
  input logic              full,
  input logic [STAT_W-1:0] status
);

  logic [2*LVL_W:0] cfg_prev;
  logic [1:0]       hold_cnt;
  logic             steady;
  logic [IDX_W-1:0] put_prev;
  logic [LVL_W:0]   lo_x, hi_x, last_x;
  logic [IDX_W-1:0] put_step;

  always_ff @(posedge clk) begin
    cfg_prev <= {cfg_queue, cfg_ded, cfg_size};
    put_prev <= put_idx;
    if (rst || ({cfg_queue, cfg_ded, cfg_size} != cfg_prev)) hold_cnt <= '0;
    else if (hold_cnt != 2'd3)                               hold_cnt <= hold_cnt + 2'd1;
  end

  always_comb begin
    steady   = (hold_cnt == 2'd3) && ({cfg_queue, cfg_ded, cfg_size} == cfg_prev);
    lo_x     = (LVL_W+1)'(cfg_ded);
    hi_x     = (LVL_W+1)'(cfg_ded) + (LVL_W+1)'(cfg_size);
    last_x   = hi_x - (LVL_W+1)'(1);
    put_step = ((LVL_W+1)'(put_prev) == last_x) ? cfg_ded[IDX_W-1:0] : IDX_W'(put_prev + 1);
  end

  p_idx_range_r1: assert property (@(posedge clk) disable iff (rst)
    steady && !cfg_queue |->
      ((LVL_W+1)'(put_idx) >= lo_x) && ((LVL_W+1)'(put_idx) < hi_x) &&
      ((LVL_W+1)'(get_idx) >= lo_x) && ((LVL_W+1)'(get_idx) < hi_x));

  p_put_advance_r2: assert property (@(posedge clk) disable iff (rst)
    steady && !cfg_queue && $past(add_stb) && !$past(full) |-> put_idx == put_step);

  p_full_free_r4: assert property (@(posedge clk) disable iff (rst)
    steady && !cfg_queue |-> full == (free_lvl == '0));

  p_free_bound_r4: assert property (@(posedge clk) disable iff (rst)
    steady |-> free_lvl <= cfg_size);

  p_add_full_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    steady && !cfg_queue && $past(add_stb) && $past(full) && !$past(done_stb) |->
      $stable(put_idx) && $stable(get_idx) && full);

  p_queue_zero_r6: assert property (@(posedge clk) disable iff (rst)
    steady && cfg_queue |-> (get_idx == '0) && (free_lvl == '0));

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> status == '0);

endmodule

bind txq_index_mgr txq_index_mgr_chk #(
  .IDX_W(IDX_W), .LVL_W(LVL_W), .STAT_W(STAT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_ded   (cfg_ded),
  .cfg_size  (cfg_size),
  .cfg_queue (cfg_queue),
  .add_stb   (add_stb),
  .done_stb  (done_stb),
  .put_idx   (put_idx),
  .get_idx   (get_idx),
  .free_lvl  (free_lvl),
  .full      (full),
  .status    (status)
);

// File: tb/txq_index_mgr_tb.sv
`timescale 1ns/1ps
module txq_index_mgr_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cfg_ded = 6'd12;
  logic [5:0]  cfg_size = 6'd20;
  logic        cfg_queue = 1'b0;
  logic        add_stb = 1'b0;
  logic        done_stb = 1'b0;
  logic [4:0]  done_idx = 5'd0;
  logic [4:0]  put_idx, get_idx;
  logic [5:0]  free_lvl;
  logic        full;
  logic [31:0] status;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit finished = 1'b0;

  // Reference model state
  int m_put, m_get, m_fill, m_ded, m_size;
  bit m_q, m_vld;
  logic [31:0] m_mask;
  int e_put = 0, e_get = 0, e_free = 0;
  bit e_full = 1'b0;

  always #2.5 clk = ~clk;

  txq_index_mgr u_dut (
    .clk(clk), .rst(rst), .cfg_ded(cfg_ded), .cfg_size(cfg_size),
    .cfg_queue(cfg_queue), .add_stb(add_stb), .done_stb(done_stb),
    .done_idx(done_idx), .put_idx(put_idx), .get_idx(get_idx),
    .free_lvl(free_lvl), .full(full), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == m_ded + m_size - 1) ? m_ded : p + 1;
  endfunction

  function automatic int q_low(input logic [31:0] m, input int d, input int s);
    for (int i = d; i < d + s; i++) if (!m[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    int lo;
    bit da, dg;
    if (rst) begin
      m_vld = 0; m_put = 0; m_get = 0; m_fill = 0; m_mask = '0;
      e_put = 0; e_get = 0; e_free = 0; e_full = 0;
    end else begin
      if (!m_vld || cfg_ded != m_ded || cfg_size != m_size || cfg_queue != m_q) begin
        m_vld = 1; m_ded = cfg_ded; m_size = cfg_size; m_q = cfg_queue;
        m_put = m_ded; m_get = m_ded; m_fill = 0; m_mask = '0;
      end else if (!m_q) begin
        da = add_stb && (m_fill != m_size);
        dg = done_stb && (m_fill != 0) && (done_idx == m_get);
        if (da) m_put = nxt(m_put);
        if (dg) m_get = nxt(m_get);
        m_fill = m_fill + int'(da) - int'(dg);
      end else begin
        lo = q_low(m_mask, m_ded, m_size);
        if (done_stb && done_idx >= m_ded && done_idx < m_ded + m_size) m_mask[done_idx] = 1'b0;
        if (add_stb && lo >= 0) m_mask[lo] = 1'b1;
      end
      if (!m_q) begin
        e_put = m_put; e_get = m_get; e_free = m_size - m_fill; e_full = (m_fill == m_size);
      end else begin
        lo = q_low(m_mask, m_ded, m_size);
        e_put = (lo >= 0) ? lo : m_ded; e_get = 0; e_free = 0; e_full = (lo < 0);
      end
    end
  end

  // Every-cycle comparison away from the rising edge
  always @(negedge clk) begin
    logic [31:0] ew;
    if (chk_on) begin
      ew = (32'(e_full) << 21) | (32'(e_put) << 16) | (32'(e_get) << 8) | 32'(e_free);
      chk(put_idx == e_put, m_q ? "R6 put" : "R2 put", put_idx, e_put);
      chk(get_idx == e_get, m_q ? "R6 get" : "R3 get", get_idx, e_get);
      chk(free_lvl == e_free, m_q ? "R6 free" : "R4 free", free_lvl, e_free);
      chk(full == e_full, m_q ? "R6 full" : "R4 full", full, e_full);
      chk(status == ew, "R7 status", status, ew);
    end
  end

  task automatic tick(input bit a, input bit d, input int i);
    @(negedge clk);
    add_stb = a; done_stb = d; done_idx = i[4:0];
    @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input int d, input int s, input bit q);
    @(negedge clk);
    cfg_ded = d[5:0]; cfg_size = s[5:0]; cfg_queue = q;
    add_stb = 0; done_stb = 0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R8: reset state
    repeat (3) @(posedge clk);
    #1;
    chk_on = 1;
    chk(status == 32'h0, "R8 reset word", status, 0);
    chk(put_idx == 0 && free_lvl == 0, "R8 reset fields", put_idx, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk(put_idx == 12 && get_idx == 12, "R8 restart put", put_idx, 12);
    chk(free_lvl == 20, "R8 restart free", free_lvl, 20);

    // R9: strobe driven between edges does not move outputs
    @(negedge clk); add_stb = 1; #1;
    chk(put_idx == 12, "R9 no change before edge", put_idx, 12);
    @(posedge clk); #1;
    chk(put_idx == 13, "R9 change after edge", put_idx, 13);
    tick(1, 0, 0); tick(1, 0, 0);
    chk(put_idx == 15, "R1 put index 15", put_idx, 15);
    chk(status == 32'h000F0C11, "R7 packed word", status, 32'h000F0C11);

    // R4/R5: fill to full then an extra add
    for (int k = 0; k < 17; k++) tick(1, 0, 0);
    chk(full == 1 && free_lvl == 0, "R4 full at zero free", free_lvl, 0);
    chk(put_idx == 12, "R2 put wrapped to ded", put_idx, 12);
    tick(1, 0, 0);
    chk(put_idx == 12 && get_idx == 12 && full == 1, "R5 add while full ignored", put_idx, 12);

    // R3: completion of a non-head buffer is ignored
    tick(0, 1, 13);
    chk(get_idx == 12 && free_lvl == 0, "R3 wrong index ignored", get_idx, 12);
    tick(0, 1, 12);
    chk(get_idx == 13 && free_lvl == 1, "R3 head completion", get_idx, 13);

    // R2/R3 wrap at the top of the range
    set_cfg(30, 2, 0);
    tick(1, 0, 0); tick(1, 0, 0);
    chk(put_idx == 30 && full == 1, "R2 wrap at 31", put_idx, 30);
    tick(0, 1, 30); tick(0, 1, 31);
    chk(get_idx == 30 && free_lvl == 2, "R3 get wrap", get_idx, 30);

    // R4 boundary: whole area as ring
    set_cfg(0, 32, 0);
    chk(free_lvl == 32, "R4 free level 32", free_lvl, 32);

    // R6 queue mode
    set_cfg(4, 3, 1);
    chk(put_idx == 4 && get_idx == 0 && free_lvl == 0, "R6 queue restart", put_idx, 4);
    tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0);
    chk(full == 1 && put_idx == 4, "R6 queue full", full, 1);
    tick(0, 1, 5);
    chk(full == 0 && put_idx == 5, "R6 lowest free after release", put_idx, 5);

    // R8: configuration change with a simultaneous add
    @(negedge clk);
    cfg_ded = 6'd3; cfg_size = 6'd9; cfg_queue = 0; add_stb = 1;
    @(posedge clk); #1;
    chk(put_idx == 3 && free_lvl == 9, "R8 restart drops strobe", put_idx, 3);

    // Constrained random phases
    for (int ph = 0; ph < 8; ph++) begin
      int d, s;
      bit q;
      d = $urandom % 16;
      s = 1 + ($urandom % (32 - d));
      q = (ph % 3 == 2);
      set_cfg(d, s, q);
      for (int c = 0; c < 400; c++) begin
        int di;
        bit a, dn;
        a  = ($urandom % 3) != 0;
        dn = ($urandom % 2) != 0;
        if (q) di = d + ($urandom % s);
        else   di = (($urandom % 5) == 0) ? int'($urandom % 32) : e_get;
        tick(a, dn, di);
      end
    end

    @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule